// File: doc/BRIEF.md
# Smart Card Activation Sequencer

This block powers up and activates an asynchronous smart card when the host asks for it. It also shuts the card down in an orderly way. All timing comes from the internal oscillator clock, nominally 1.5 MHz, so every delay is a cycle count set by a parameter. After the logic supply becomes valid (the release of `rst_n`), a lockout window of about 10 ms blocks every activation request.

A session opens only on a high-to-low transition of the active-low host command. The card must be present and no supply fault may be flagged. The sequencer then turns on the card supply, opens the I/O path for reception, and starts the card clock. Once the clock runs, the card reset pin follows the host's reset request.

A session ends in one of three ways: a rising edge of the host command, loss of the card, or a supply fault. In each case the sequencer tears the session down in reverse order, with a fixed gap between steps. It then waits in idle for a fresh falling edge. A status line tells the host whether a card is inserted while idle, and whether a fault ended the session while one is open.

Top module: `sc_act_seq`

## Requirements
- R1: For LOCK_CYC cycles after reset release, a falling edge on `cmd_n` has no effect: `vcc_en` stays 0.
- R2: Activation needs a 1-to-0 transition of `cmd_n`. Holding `cmd_n` low with no new transition never starts a session.
- R3: A falling edge while `card_present` is 0, or while `supply_fault` is 1, leaves `vcc_en` at 0.
- R4: After an accepted falling edge, `vcc_en` goes high at the next clock edge. `io_en` goes high ACT_CYC cycles later, and `clk_en` goes high ACT_CYC cycles after that. `clk_en` implies `io_en`, and `io_en` implies `vcc_en`.
- R5: `card_rst` equals `host_rst` while the card clock runs in an open session. It is 0 at all other times.
- R6: `vcc_5v` takes the value of `sel_5v` at activation start (1 selects the higher card voltage). It holds that value through the whole session.
- R7: Outside a session, `off_n` equals `card_present`.
- R8: Inside a session, `off_n` is 1 until card loss or a supply fault is seen. From the next cycle until the session ends, it is 0.
- R9: Card loss or a supply fault during a session forces `card_rst` to 0 at once. `clk_en` then drops DEACT_CYC cycles later, `io_en` another DEACT_CYC cycles later, and `vcc_en` another DEACT_CYC cycles later. The block returns to idle after a final DEACT_CYC cycles.
- R10: A rising edge of `cmd_n` during a session runs the same teardown as R9, with `off_n` staying 1.
- R11: After teardown the block is idle, and a new falling edge of `cmd_n` is needed to activate again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Active-low reset; release marks logic supply valid |
| cmd_n | input | 1 | Host command, active low, edge sensitive |
| card_present | input | 1 | Card inserted |
| supply_fault | input | 1 | Supply fault flag |
| host_rst | input | 1 | Host reset request for the card |
| sel_5v | input | 1 | Card voltage select (1 = high voltage) |
| vcc_en | output | 1 | Card supply enable |
| vcc_5v | output | 1 | Latched voltage select |
| io_en | output | 1 | I/O path enabled in reception state |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset pin level |
| off_n | output | 1 | Status to host: presence when idle, no-fault in session |

## Verification
On every cycle, the assertions check the nesting of the enables (clock implies I/O, I/O implies supply) and the teardown order at each falling enable. They also check that the lockout blocks the supply, that activation happened with a card present and no fault, that the reset pin is gated by the running clock, and that the voltage choice stays stable. Only the directed scenarios can show the exact cycle counts between steps, the edge-versus-level distinction, the status line's meaning in each phase, and the need for a fresh edge after teardown.

// File: rtl/sc_seq_pkg.sv
package sc_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_IO,
    ST_RUN,
    ST_D_RST,
    ST_D_CLK,
    ST_D_IO,
    ST_D_PWR
  } seq_state_t;

  // States in which an abort condition starts teardown
  function automatic logic is_opening(seq_state_t s);
    return (s == ST_PWR) || (s == ST_IO) || (s == ST_RUN);
  endfunction

  // Dwell length of a timed state, in oscillator cycles
  function automatic int unsigned dwell_cycles(seq_state_t s,
                                               int unsigned act_c,
                                               int unsigned deact_c);
    if ((s == ST_PWR) || (s == ST_IO)) return act_c;
    return deact_c;
  endfunction

endpackage

// File: rtl/sc_lockout.sv
module sc_lockout #(
  parameter int unsigned LOCK_CYC = 15000
) (
  input  logic clk,
  input  logic rst_n,
  output logic done
);
  localparam int unsigned W = $clog2(LOCK_CYC + 1);
  localparam logic [W-1:0] LIM = W'(LOCK_CYC);

  logic [W-1:0] cnt;

  assign done = (cnt == LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sc_edge_det.sv
module sc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_n,
  output logic fall,
  output logic rise
);
  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b1;
    else        q <= sig_n;
  end

  assign fall = q & ~sig_n;
  assign rise = ~q & sig_n;
endmodule

// File: rtl/sc_step_timer.sv
module sc_step_timer #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         done
);
  logic [W-1:0] cnt;

  assign done = (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sc_act_seq.sv
module sc_act_seq
  import sc_seq_pkg::*;
#(
  parameter int unsigned LOCK_CYC  = 15000,
  parameter int unsigned ACT_CYC   = 383,
  parameter int unsigned DEACT_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_n,
  input  logic card_present,
  input  logic supply_fault,
  input  logic host_rst,
  input  logic sel_5v,
  output logic vcc_en,
  output logic vcc_5v,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic off_n
);
  localparam int unsigned MAXC = (ACT_CYC > DEACT_CYC) ? ACT_CYC : DEACT_CYC;
  localparam int unsigned TW   = $clog2(MAXC + 1);

  seq_state_t state, state_nx;

  logic lock_done, cmd_fall, cmd_rise;
  logic step_done, step_restart;
  logic [TW-1:0] step_limit;
  logic abort_evt, trouble, in_session;
  logic vcc_r, v5_r, io_r, clk_r, fault_r;

  sc_lockout #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .done(lock_done)
  );

  sc_edge_det u_edge (
    .clk(clk), .rst_n(rst_n), .sig_n(cmd_n),
    .fall(cmd_fall), .rise(cmd_rise)
  );

  assign step_limit   = TW'(dwell_cycles(state, ACT_CYC, DEACT_CYC));
  assign step_restart = (state_nx != state);

  sc_step_timer #(.W(TW)) u_step (
    .clk(clk), .rst_n(rst_n), .restart(step_restart),
    .limit(step_limit), .done(step_done)
  );

  assign trouble    = ~card_present | supply_fault;
  assign abort_evt  = trouble | cmd_rise;
  assign in_session = (state != ST_IDLE);

  always_comb begin
    state_nx = state;
    if (is_opening(state) && abort_evt) begin
      state_nx = ST_D_RST;
    end else begin
      case (state)
        ST_IDLE:  if (cmd_fall && lock_done && card_present && !supply_fault)
                    state_nx = ST_PWR;
        ST_PWR:   if (step_done) state_nx = ST_IO;
        ST_IO:    if (step_done) state_nx = ST_RUN;
        ST_D_RST: if (step_done) state_nx = ST_D_CLK;
        ST_D_CLK: if (step_done) state_nx = ST_D_IO;
        ST_D_IO:  if (step_done) state_nx = ST_D_PWR;
        ST_D_PWR: if (step_done) state_nx = ST_IDLE;
        default:  state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      vcc_r   <= 1'b0;
      v5_r    <= 1'b0;
      io_r    <= 1'b0;
      clk_r   <= 1'b0;
      fault_r <= 1'b0;
    end else begin
      state <= state_nx;
      if (state_nx == ST_IDLE)            fault_r <= 1'b0;
      else if (in_session && trouble)     fault_r <= 1'b1;
      if (state_nx != state) begin
        case (state_nx)
          ST_PWR:   begin vcc_r <= 1'b1; v5_r <= sel_5v; end
          ST_IO:    io_r  <= 1'b1;
          ST_RUN:   clk_r <= 1'b1;
          ST_D_CLK: clk_r <= 1'b0;
          ST_D_IO:  io_r  <= 1'b0;
          ST_D_PWR: vcc_r <= 1'b0;
          default:  ;
        endcase
      end
    end
  end

  assign vcc_en   = vcc_r;
  assign vcc_5v   = v5_r;
  assign io_en    = io_r;
  assign clk_en   = clk_r;
  assign card_rst = (state == ST_RUN) & host_rst;
  assign off_n    = in_session ? ~fault_r : card_present;

endmodule

// File: rtl/sc_act_seq_chk.sv
module sc_act_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic card_present,
  input logic supply_fault,
  input logic host_rst,
  input logic vcc_en,
  input logic vcc_5v,
  input logic io_en,
  input logic clk_en,
  input logic card_rst,
  input logic lock_done
);
  // R1
  lockout_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_done |-> !vcc_en);

  // R3
  gated_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vcc_en) |-> $past(card_present && !supply_fault && lock_done));

  // R4
  clk_needs_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_en);

  // R4
  io_needs_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en);

  // R5
  rst_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (clk_en && host_rst));

  // R6
  volt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_en && $past(vcc_en)) |-> $stable(vcc_5v));

  // R9
  vcc_off_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vcc_en) |-> !io_en);

  // R9
  io_off_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_en) |-> !clk_en);
endmodule

bind sc_act_seq sc_act_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .card_present(card_present),
  .supply_fault(supply_fault), .host_rst(host_rst),
  .vcc_en(vcc_en), .vcc_5v(vcc_5v), .io_en(io_en), .clk_en(clk_en),
  .card_rst(card_rst), .lock_done(lock_done)
);

// File: tb/sc_act_seq_tb.sv
`timescale 1ns/1ps
module sc_act_seq_tb;
  localparam int LOCK = 200;
  localparam int A    = 20;
  localparam int K    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_n = 1'b1, card_present = 1'b1, supply_fault = 1'b0;
  logic host_rst = 1'b0, sel_5v = 1'b0;
  logic vcc_en, vcc_5v, io_en, clk_en, card_rst, off_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sc_act_seq #(.LOCK_CYC(LOCK), .ACT_CYC(A), .DEACT_CYC(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_n(cmd_n), .card_present(card_present),
    .supply_fault(supply_fault), .host_rst(host_rst), .sel_5v(sel_5v),
    .vcc_en(vcc_en), .vcc_5v(vcc_5v), .io_en(io_en), .clk_en(clk_en),
    .card_rst(card_rst), .off_n(off_n)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic fall_cmd();
    cmd_n = 1'b1; step(1);
    cmd_n = 1'b0; step(1);
  endtask

  task automatic t_reset();
    chk("R7", "off_n in reset", off_n, 1);
    chk("R4", "vcc_en in reset", vcc_en, 0);
    chk("R5", "card_rst in reset", card_rst, 0);
  endtask

  task automatic t_lockout();
    step(40);
    fall_cmd();
    step(10);
    chk("R1", "vcc_en after early edge", vcc_en, 0);
    cmd_n = 1'b1;
    step(LOCK);
  endtask

  task automatic t_gate();
    card_present = 1'b0; step(1);
    chk("R7", "off_n with no card", off_n, 0);
    fall_cmd(); step(3);
    chk("R3", "vcc_en with no card", vcc_en, 0);
    card_present = 1'b1; step(1);
    chk("R7", "off_n with card idle", off_n, 1);
    supply_fault = 1'b1;
    fall_cmd(); step(3);
    chk("R3", "vcc_en with fault", vcc_en, 0);
  endtask

  task automatic t_level();
    supply_fault = 1'b0;
    step(10);
    chk("R2", "vcc_en with held low", vcc_en, 0);
  endtask

  // Activation from an edge; checks timing, voltage capture and reset follow
  task automatic t_activate(logic v5);
    sel_5v = v5; host_rst = 1'b1;
    cmd_n = 1'b1; step(1);
    cmd_n = 1'b0; step(1);
    chk("R4", "vcc_en at +1", vcc_en, 1);
    chk("R4", "io_en at +1", io_en, 0);
    chk("R6", "vcc_5v captured", vcc_5v, v5);
    sel_5v = ~v5;
    step(A - 1);
    chk("R4", "io_en at +A", io_en, 0);
    step(1);
    chk("R4", "io_en at +A+1", io_en, 1);
    chk("R5", "card_rst before clock", card_rst, 0);
    step(A - 1);
    chk("R4", "clk_en at +2A", clk_en, 0);
    step(1);
    chk("R4", "clk_en at +2A+1", clk_en, 1);
    chk("R5", "card_rst follows high", card_rst, 1);
    chk("R6", "vcc_5v held", vcc_5v, v5);
    chk("R8", "off_n in healthy session", off_n, 1);
    host_rst = 1'b0; #1;
    chk("R5", "card_rst follows low", card_rst, 0);
    host_rst = 1'b1; step(2);
  endtask

  // Teardown timing; exp_off is off_n expected during the session
  task automatic t_teardown(string req, int exp_off);
    step(1);
    chk(req, "card_rst at +1", card_rst, 0);
    chk(req, "clk_en at +1", clk_en, 1);
    chk("R8", "off_n at +1", off_n, exp_off);
    step(K - 1);
    chk(req, "clk_en at +K", clk_en, 1);
    step(1);
    chk(req, "clk_en at +K+1", clk_en, 0);
    chk(req, "io_en at +K+1", io_en, 1);
    step(K);
    chk(req, "io_en at +2K+1", io_en, 0);
    chk(req, "vcc_en at +2K+1", vcc_en, 1);
    step(K);
    chk(req, "vcc_en at +3K+1", vcc_en, 0);
    step(K - 1);
    chk("R8", "off_n at +4K", off_n, exp_off);
    step(1);
    chk("R7", "off_n back to presence", off_n, card_present);
  endtask

  task automatic t_fault_deact();
    t_activate(1'b1);
    supply_fault = 1'b1;
    t_teardown("R9", 0);
    supply_fault = 1'b0;
    step(10);
    chk("R11", "no restart without edge", vcc_en, 0);
  endtask

  task automatic t_host_deact();
    t_activate(1'b0);
    cmd_n = 1'b1;
    t_teardown("R10", 1);
    step(5);
    chk("R11", "idle after host teardown", vcc_en, 0);
  endtask

  task automatic t_removal();
    t_activate(1'b1);
    card_present = 1'b0;
    t_teardown("R9", 0);
    chk("R7", "off_n no card after teardown", off_n, 0);
    card_present = 1'b1;
    cmd_n = 1'b1; step(2);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_lockout();
    t_gate();
    t_level();
    t_fault_deact();
    t_host_deact();
    t_removal();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule